// File: doc/BRIEF.md
# Four-Phase Handshake Interleaving Sequencer

This block is a clocked model of an asynchronous control element. The environment starts it through one passive activation channel. The block answers by running one four-phase handshake on each of its two active channels, A and B, and then acknowledges the activation. A static mode input selects how the two handshakes are interleaved:

- **Sequenced mode:** B starts only once A has fully returned to zero.
- **Enclosed mode:** the whole of B's handshake takes place inside A's handshake, between A's acknowledge rising and A's request falling.

All inputs are sampled on one clock, and every output comes straight from a flip-flop. A response therefore appears on the clock edge that follows the input change that caused it. While an acknowledge keeps the value the protocol is waiting for, the block holds its current state for as long as that lasts.

Top module: `hs_interleave_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `act_ack`, `a_req` and `b_req` are low and the block is idle.
- R2: When `act_req` is seen high while idle, `a_req` rises on that same clock edge, so it is visible one cycle after `act_req` was driven.
- R3: A request output changes only when its acknowledge matches the protocol. `a_req`/`b_req` rise only while the matching acknowledge is low. They fall only after the matching acknowledge has been seen high. Otherwise they hold indefinitely.
- R4: With `mode_enc`=0 (sequenced), `b_req` rises only after `a_req` and `a_ack` are both back at 0.
- R5: With `mode_enc`=1 (enclosed), `b_req` rises only while `a_req` and `a_ack` are both 1. `a_req` falls only after `b_req` and `b_ack` are both back at 0.
- R6: `act_ack` rises only when `act_req` is 1 and all of `a_req`, `a_ack`, `b_req` and `b_ack` are 0.
- R7: `act_ack` falls only after `act_req` has been seen low, and stays high as long as `act_req` stays high.
- R8: `mode_enc` is captured when an activation starts. Changing it before that activation returns to idle has no effect on that activation's ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_enc | input | 1 | Interleaving select: 0 sequenced, 1 enclosed |
| act_req | input | 1 | Activation request from the environment |
| act_ack | output | 1 | Activation acknowledge |
| a_req | output | 1 | Request on active channel A |
| a_ack | input | 1 | Acknowledge on channel A |
| b_req | output | 1 | Request on active channel B |
| b_ack | input | 1 | Acknowledge on channel B |

## Verification
The bound checker checks the following on every cycle:
- each request edge against the acknowledge value that should permit it;
- the position of B's request relative to A's channel, in the captured mode;
- the conditions for raising and lowering the activation acknowledge.

Some behaviours only the bench scenarios can show. These are:
- that each step really happens one cycle after its trigger;
- that a stalled responder freezes the block;
- that flipping the mode input mid-activation leaves the captured ordering alone;
- that the full sequence of edges in each mode matches the expected order.

// File: rtl/hs_interleave_seq.sv
module hs_interleave_seq (
  input  logic clk,
  input  logic rst,
  input  logic mode_enc,
  input  logic act_req,
  output logic act_ack,
  output logic a_req,
  input  logic a_ack,
  output logic b_req,
  input  logic b_ack
);

  typedef enum logic [2:0] {IDLE, A_UP, A_DN, B_UP, B_DN, DONE} st_t;

  st_t  st;
  logic mode_q;
  logic act_ack_q, a_req_q, b_req_q;

  assign act_ack = act_ack_q;
  assign a_req   = a_req_q;
  assign b_req   = b_req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= IDLE;
      mode_q    <= 1'b0;
      act_ack_q <= 1'b0;
      a_req_q   <= 1'b0;
      b_req_q   <= 1'b0;
    end else begin
      case (st)
        IDLE: if (act_req) begin
          mode_q  <= mode_enc;
          a_req_q <= 1'b1;
          st      <= A_UP;
        end
        A_UP: if (a_ack) begin
          if (mode_q) begin
            b_req_q <= 1'b1;
            st      <= B_UP;
          end else begin
            a_req_q <= 1'b0;
            st      <= A_DN;
          end
        end
        A_DN: if (!a_ack) begin
          if (mode_q) begin
            act_ack_q <= 1'b1;
            st        <= DONE;
          end else begin
            b_req_q <= 1'b1;
            st      <= B_UP;
          end
        end
        B_UP: if (b_ack) begin
          b_req_q <= 1'b0;
          st      <= B_DN;
        end
        B_DN: if (!b_ack) begin
          if (mode_q) begin
            a_req_q <= 1'b0;
            st      <= A_DN;
          end else begin
            act_ack_q <= 1'b1;
            st        <= DONE;
          end
        end
        DONE: if (!act_req) begin
          act_ack_q <= 1'b0;
          st        <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hs_interleave_seq_chk.sv
module hs_interleave_seq_chk (
  input logic clk,
  input logic rst,
  input logic mode_q,
  input logic act_req,
  input logic act_ack,
  input logic a_req,
  input logic a_ack,
  input logic b_req,
  input logic b_ack
);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !act_ack && !a_req && !b_req);

  a_r3_a_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(a_req) |-> !$past(a_ack));
  a_r3_a_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(a_req) |-> $past(a_ack));
  a_r3_b_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(b_req) |-> !$past(b_ack));
  a_r3_b_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(b_req) |-> $past(b_ack));

  a_r4_seq_order: assert property (@(posedge clk) disable iff (rst)
    ($rose(b_req) && !mode_q) |-> !a_req && !$past(a_ack));

  a_r5_enc_inside: assert property (@(posedge clk) disable iff (rst)
    ($rose(b_req) && mode_q) |-> a_req && $past(a_ack));
  a_r5_enc_a_fall: assert property (@(posedge clk) disable iff (rst)
    ($fell(a_req) && mode_q) |-> !b_req && !$past(b_ack));

  a_r6_ack_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(act_ack) |-> $past(act_req) && !a_req && !b_req && !$past(a_ack) && !$past(b_ack));

  a_r7_ack_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(act_ack) |-> !$past(act_req));

endmodule

bind hs_interleave_seq hs_interleave_seq_chk u_chk (
  .clk(clk), .rst(rst), .mode_q(mode_q), .act_req(act_req), .act_ack(act_ack),
  .a_req(a_req), .a_ack(a_ack), .b_req(b_req), .b_ack(b_ack)
);

// File: tb/hs_interleave_seq_bench.sv
module hs_interleave_seq_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_enc = 1'b0, act_req = 1'b0, a_ack = 1'b0, b_ack = 1'b0;
  logic act_ack, a_req, b_req;
  int   checks = 0, errors = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  hs_interleave_seq u_hs_interleave_seq (
    .clk(clk), .rst(rst), .mode_enc(mode_enc), .act_req(act_req), .act_ack(act_ack),
    .a_req(a_req), .a_ack(a_ack), .b_req(b_req), .b_ack(b_ack)
  );

  // {mode, act_req, a_ack, b_ack, exp act_ack, exp a_req, exp b_req}
  localparam logic [6:0] VEC [12] = '{
    7'b0100_010, 7'b0110_000, 7'b0100_001, 7'b0101_000, 7'b0100_100, 7'b0000_000,
    7'b1100_010, 7'b1110_011, 7'b1111_010, 7'b1110_000, 7'b1100_100, 7'b1000_000
  };

  task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {act_ack,a_req,b_req} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic m, input logic ar, input logic aa, input logic ba);
    @(negedge clk);
    mode_enc = m; act_req = ar; a_ack = aa; b_ack = ba;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1 reset", {act_ack, a_req, b_req}, 3'b000);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1 chk("R1 idle after reset", {act_ack, a_req, b_req}, 3'b000);

    // R4 sequenced and R5 enclosed full handshakes
    for (int i = 0; i < 12; i++) begin
      drive(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
      chk(VEC[i][6] ? "R5 enclosed step" : "R4 sequenced step",
          {act_ack, a_req, b_req}, VEC[i][2:0]);
    end

    // R2: one cycle latency of a_req after act_req
    drive(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 a_req rises", {act_ack, a_req, b_req}, 3'b010);

    // R3: stalled A responder freezes the block
    repeat (20) drive(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 stall a_ack low", {act_ack, a_req, b_req}, 3'b010);

    // R8: mode flips to enclosed mid-activation, sequenced order kept
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R8 captured mode a_req falls", {act_ack, a_req, b_req}, 3'b000);

    // R6: a_ack held high, no activation acknowledge yet
    repeat (5) drive(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R6 wait a_ack low", {act_ack, a_req, b_req}, 3'b000);
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R8 b_req after A rtz", {act_ack, a_req, b_req}, 3'b001);
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R3 b_req falls", {act_ack, a_req, b_req}, 3'b000);

    // R3: b_ack held high keeps the block waiting
    repeat (6) drive(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R6 wait b_ack low", {act_ack, a_req, b_req}, 3'b000);
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R6 act_ack rises", {act_ack, a_req, b_req}, 3'b100);

    // R7: act_ack holds while act_req stays high
    repeat (10) drive(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R7 act_ack held", {act_ack, a_req, b_req}, 3'b100);
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7 act_ack falls", {act_ack, a_req, b_req}, 3'b000);

    // R5: enclosed, stall with b outstanding keeps a_req high
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    repeat (8) drive(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R5 b inside A stalled", {act_ack, a_req, b_req}, 3'b011);

    // R1: reset mid-handshake returns to idle
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1 chk("R1 reset mid-handshake", {act_ack, a_req, b_req}, 3'b000);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule